// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the arbitration core of an eight-line interrupt controller. Each request line can be set to edge or level capture. The block keeps four registers: pending requests, a mask, the levels now in service, and the trigger mode of each line. Priority rotates. It is counted from a programmable base level, and the first pending, unmasked line found walking upward from that base wins. The interrupt output rises only when that winner ranks strictly above every level already in service.

Software or a sequencer outside the block drives three things: a command strobe carrying a 3-bit operation code and a 3-bit level, an acknowledge strobe carrying the level being taken, and two quasi-static mode inputs. The mode inputs select automatic end-of-interrupt and the nested exclusion of the cascade line. The block decodes no bus addresses and does not cascade to other instances itself. When the instance is built as a master, it only removes its cascade line from the in-service ranking while nested mode is on.

Top module: `irq_prio_core`

## Requirements
- R1: With trigger bit 0 (edge), a pending bit is set only on the edge where the line is low in one cycle and high in the next. A falling line leaves the pending bit set, and a line held high does not set the bit again after it has been cleared.
- R2: With trigger bit 1 (level), the pending bit copies the line's value sampled at each clock edge, and an acknowledge does not clear it.
- R3: The priority offset of a set is the smallest p in 0..7 such that bit (p + base) mod 8 is set, and 8 for an empty set. `irq_lvl_o` is (p + base) mod 8 for the pending-and-unmasked set.
- R4: `irq_o` is high exactly when the offset of (pending AND NOT mask) is strictly less than the offset of the in-service set. Masked lines never cause `irq_o`.
- R5: When the instance is the master and `nested_i` is high, in-service bit 2 (the cascade line) is left out of the in-service offset.
- R6: An acknowledge at level L sets in-service bit L. It clears pending bit L only when line L is in edge mode.
- R7: With `auto_eoi_i` high, an acknowledge leaves in-service bit L clear. If the rotate flag is set, it also moves the base to (L+1) mod 8. Code 4 sets the rotate flag and code 0 clears it.
- R8: Code 1 clears the in-service bit with the smallest offset. Code 5 does the same and moves the base to that level + 1. Both do nothing when no level is in service.
- R9: Code 3 clears in-service bit `cmd_lvl_i`. Code 7 clears it and moves the base to `cmd_lvl_i` + 1.
- R10: Code 6 moves the base to `cmd_lvl_i` + 1 and leaves the in-service bits unchanged. Code 2 changes no state.
- R11: After reset, the pending, mask, trigger, in-service, last-line, rotate-flag and base registers are all zero, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Request lines |
| mask_wr_i | input | 1 | Load strobe for the mask register |
| mask_i | input | 8 | New mask value, 1 = masked |
| trig_wr_i | input | 1 | Load strobe for the trigger-mode register |
| trig_i | input | 8 | New trigger modes, 1 = level, 0 = edge |
| nested_i | input | 1 | Nested mode, which excludes the cascade line from ranking |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt on acknowledge |
| cmd_vld_i | input | 1 | Command strobe |
| cmd_code_i | input | 3 | Command operation code |
| cmd_lvl_i | input | 3 | Command level operand |
| ack_i | input | 1 | Acknowledge strobe |
| ack_lvl_i | input | 3 | Level being acknowledged |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_lvl_o | output | 3 | Winning level, meaningful while `irq_o` is high |
| req_o | output | 8 | Pending register readback |
| insvc_o | output | 8 | In-service register readback |
| base_o | output | 3 | Rotation base readback |

## Verification
The bench builds the block with eight lines, the master variant enabled and the cascade line on pin 2. With these settings the nested exclusion can be reached and checked against a plain in-service ranking. Random traffic toggles the lines, the mask and the trigger modes, and issues every command code alongside acknowledges. This drives the base through all eight positions, so wrap-around in the priority walk is covered, and it produces the collisions of acknowledge with command and of acknowledge with a new edge that directed cases miss.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

  typedef enum logic [2:0] {
    OP_ROT_AUTO_OFF = 3'd0,
    OP_EOI_TOP      = 3'd1,
    OP_IDLE         = 3'd2,
    OP_EOI_LVL      = 3'd3,
    OP_ROT_AUTO_ON  = 3'd4,
    OP_EOI_TOP_ROT  = 3'd5,
    OP_SET_BASE     = 3'd6,
    OP_EOI_LVL_ROT  = 3'd7
  } irqp_op_e;

endpackage

// File: rtl/irqp_resolver.sv
// Rotating-priority search over a bit set: offset and level of first set bit
module irqp_resolver #(
  parameter int N_LINES = 8,
  localparam int LVL_W  = $clog2(N_LINES),
  localparam int PRIO_W = LVL_W + 1
) (
  input  logic [N_LINES-1:0] set_i,
  input  logic [LVL_W-1:0]   base_i,
  output logic [PRIO_W-1:0]  prio_o,
  output logic [LVL_W-1:0]   lvl_o
);

  logic [LVL_W-1:0] idx;

  always_comb begin
    prio_o = PRIO_W'(N_LINES);
    lvl_o  = '0;
    idx    = '0;
    for (int p = N_LINES - 1; p >= 0; p--) begin
      idx = base_i + LVL_W'(p);
      if (set_i[idx]) begin
        prio_o = PRIO_W'(p);
        lvl_o  = idx;
      end
    end
  end

endmodule

// File: rtl/irqp_capture.sv
// Request capture, mask and trigger-mode registers
module irqp_capture #(
  parameter int N_LINES = 8,
  localparam int LVL_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_i,
  input  logic               mask_wr_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic               trig_wr_i,
  input  logic [N_LINES-1:0] trig_i,
  input  logic               ack_i,
  input  logic [LVL_W-1:0]   ack_lvl_i,
  output logic [N_LINES-1:0] req_o,
  output logic [N_LINES-1:0] mask_o
);

  logic [N_LINES-1:0] req_q, req_d;
  logic [N_LINES-1:0] last_q;
  logic [N_LINES-1:0] mask_q, mask_d;
  logic [N_LINES-1:0] trig_q, trig_d;
  logic [N_LINES-1:0] ack_hit;

  for (genvar i = 0; i < N_LINES; i++) begin : g_pin
    assign ack_hit[i] = ack_i && (ack_lvl_i == LVL_W'(i));

    always_comb begin
      if (trig_q[i]) begin
        req_d[i] = req_i[i];
      end else begin
        req_d[i] = (req_q[i] && !ack_hit[i]) || (req_i[i] && !last_q[i]);
      end
    end

    // R2
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_q[i] |=> (req_q[i] == $past(req_i[i])));

    // R1
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_q[i] && req_q[i] && !ack_hit[i]) |=> req_q[i]);
  end

  always_comb begin
    mask_d = mask_q;
    trig_d = trig_q;
    if (mask_wr_i) mask_d = mask_i;
    if (trig_wr_i) trig_d = trig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      last_q <= '0;
      mask_q <= '0;
      trig_q <= '0;
    end else begin
      req_q  <= req_d;
      last_q <= req_i;
      mask_q <= mask_d;
      trig_q <= trig_d;
    end
  end

  assign req_o  = req_q;
  assign mask_o = mask_q;

endmodule

// File: rtl/irqp_service.sv
// In-service register, rotation base and command execution
module irqp_service
  import irqp_pkg::*;
#(
  parameter int N_LINES = 8,
  localparam int LVL_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_vld_i,
  input  logic [2:0]         cmd_code_i,
  input  logic [LVL_W-1:0]   cmd_lvl_i,
  input  logic               ack_i,
  input  logic [LVL_W-1:0]   ack_lvl_i,
  input  logic               auto_eoi_i,
  input  logic               eoi_hit_i,
  input  logic [LVL_W-1:0]   eoi_lvl_i,
  output logic [N_LINES-1:0] insvc_o,
  output logic [LVL_W-1:0]   base_o
);

  logic [N_LINES-1:0] insvc_q, insvc_d, clr_vec;
  logic [LVL_W-1:0]   base_q, base_d;
  logic               rot_q, rot_d;
  irqp_op_e           op;

  assign op = irqp_op_e'(cmd_code_i);

  always_comb begin
    clr_vec = '0;
    base_d  = base_q;
    rot_d   = rot_q;
    if (cmd_vld_i) begin
      unique case (op)
        OP_ROT_AUTO_OFF, OP_ROT_AUTO_ON: rot_d = cmd_code_i[2];
        OP_EOI_TOP, OP_EOI_TOP_ROT: begin
          if (eoi_hit_i) begin
            clr_vec[eoi_lvl_i] = 1'b1;
            if (op == OP_EOI_TOP_ROT) base_d = eoi_lvl_i + 1'b1;
          end
        end
        OP_EOI_LVL: clr_vec[cmd_lvl_i] = 1'b1;
        OP_EOI_LVL_ROT: begin
          clr_vec[cmd_lvl_i] = 1'b1;
          base_d = cmd_lvl_i + 1'b1;
        end
        OP_SET_BASE: base_d = cmd_lvl_i + 1'b1;
        default: ;
      endcase
    end
    insvc_d = insvc_q & ~clr_vec;
    if (ack_i) begin
      if (auto_eoi_i) begin
        insvc_d[ack_lvl_i] = 1'b0;
        if (rot_q) base_d = ack_lvl_i + 1'b1;
      end else begin
        insvc_d[ack_lvl_i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insvc_q <= '0;
      base_q  <= '0;
      rot_q   <= 1'b0;
    end else begin
      insvc_q <= insvc_d;
      base_q  <= base_d;
      rot_q   <= rot_d;
    end
  end

  assign insvc_o = insvc_q;
  assign base_o  = base_q;

  // R6
  ack_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !auto_eoi_i) |=> insvc_q[$past(ack_lvl_i)]);

  // R7
  auto_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && auto_eoi_i && !cmd_vld_i) |=> !insvc_q[$past(ack_lvl_i)]);

  // R8
  eoi_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_i && cmd_code_i == 3'd5 && eoi_hit_i && !ack_i)
      |=> (base_q == LVL_W'($past(eoi_lvl_i) + 1'b1)));

  // R9
  eoi_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_i && cmd_code_i == 3'd3 && !ack_i) |=> !insvc_q[$past(cmd_lvl_i)]);

  // R10
  idle_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_i && cmd_code_i == 3'd2 && !ack_i) |=> ($stable(insvc_q) && $stable(base_q)));

endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
  parameter int N_LINES     = 8,
  parameter bit IS_MASTER   = 1'b1,
  parameter int CASCADE_PIN = 2,
  localparam int LVL_W      = $clog2(N_LINES),
  localparam int PRIO_W     = LVL_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_i,
  input  logic               mask_wr_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic               trig_wr_i,
  input  logic [N_LINES-1:0] trig_i,
  input  logic               nested_i,
  input  logic               auto_eoi_i,
  input  logic               cmd_vld_i,
  input  logic [2:0]         cmd_code_i,
  input  logic [LVL_W-1:0]   cmd_lvl_i,
  input  logic               ack_i,
  input  logic [LVL_W-1:0]   ack_lvl_i,
  output logic               irq_o,
  output logic [LVL_W-1:0]   irq_lvl_o,
  output logic [N_LINES-1:0] req_o,
  output logic [N_LINES-1:0] insvc_o,
  output logic [LVL_W-1:0]   base_o
);

  logic [N_LINES-1:0] req_q, mask_q, insvc_q, pend_set, rank_set;
  logic [LVL_W-1:0]   base_q, pend_lvl, eoi_lvl, cur_lvl_unused;
  logic [PRIO_W-1:0]  pend_prio, eoi_prio, cur_prio;

  irqp_capture #(.N_LINES(N_LINES)) i_capture (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .mask_wr_i(mask_wr_i), .mask_i(mask_i),
    .trig_wr_i(trig_wr_i), .trig_i(trig_i),
    .ack_i(ack_i), .ack_lvl_i(ack_lvl_i),
    .req_o(req_q), .mask_o(mask_q)
  );

  irqp_service #(.N_LINES(N_LINES)) i_service (
    .clk(clk), .rst_n(rst_n),
    .cmd_vld_i(cmd_vld_i), .cmd_code_i(cmd_code_i), .cmd_lvl_i(cmd_lvl_i),
    .ack_i(ack_i), .ack_lvl_i(ack_lvl_i), .auto_eoi_i(auto_eoi_i),
    .eoi_hit_i(!eoi_prio[PRIO_W-1]), .eoi_lvl_i(eoi_lvl),
    .insvc_o(insvc_q), .base_o(base_q)
  );

  assign pend_set = req_q & ~mask_q;

  if (IS_MASTER) begin : g_master
    always_comb begin
      rank_set = insvc_q;
      if (nested_i) rank_set[CASCADE_PIN] = 1'b0;
    end
  end else begin : g_slave
    assign rank_set = insvc_q;
  end

  irqp_resolver #(.N_LINES(N_LINES)) i_pend_res (
    .set_i(pend_set), .base_i(base_q), .prio_o(pend_prio), .lvl_o(pend_lvl));

  irqp_resolver #(.N_LINES(N_LINES)) i_eoi_res (
    .set_i(insvc_q), .base_i(base_q), .prio_o(eoi_prio), .lvl_o(eoi_lvl));

  irqp_resolver #(.N_LINES(N_LINES)) i_cur_res (
    .set_i(rank_set), .base_i(base_q), .prio_o(cur_prio), .lvl_o(cur_lvl_unused));

  assign irq_o     = pend_prio < cur_prio;
  assign irq_lvl_o = pend_lvl;
  assign req_o     = req_q;
  assign insvc_o   = insvc_q;
  assign base_o    = base_q;

  // R4
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (req_q[irq_lvl_o] && !mask_q[irq_lvl_o]));

  // R3
  irq_not_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !nested_i) |-> !insvc_q[irq_lvl_o]);

endmodule

// File: tb/test_irq_prio_core.sv
module test_irq_prio_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_i = '0, mask_i = '0, trig_i = '0;
  logic       mask_wr_i = 1'b0, trig_wr_i = 1'b0, nested_i = 1'b0, auto_eoi_i = 1'b0;
  logic       cmd_vld_i = 1'b0, ack_i = 1'b0;
  logic [2:0] cmd_code_i = '0, cmd_lvl_i = '0, ack_lvl_i = '0;
  logic       irq_o;
  logic [2:0] irq_lvl_o, base_o;
  logic [7:0] req_o, insvc_o;

  int errors = 0;
  int checks = 0;

  logic [7:0] m_req, m_last, m_mask, m_trig, m_isr;
  logic [2:0] m_base;
  logic       m_rot;

  irq_prio_core #(.N_LINES(8), .IS_MASTER(1'b1), .CASCADE_PIN(2)) i_irq_prio_core (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_wr_i(mask_wr_i), .mask_i(mask_i),
    .trig_wr_i(trig_wr_i), .trig_i(trig_i), .nested_i(nested_i), .auto_eoi_i(auto_eoi_i),
    .cmd_vld_i(cmd_vld_i), .cmd_code_i(cmd_code_i), .cmd_lvl_i(cmd_lvl_i),
    .ack_i(ack_i), .ack_lvl_i(ack_lvl_i), .irq_o(irq_o), .irq_lvl_o(irq_lvl_o),
    .req_o(req_o), .insvc_o(insvc_o), .base_o(base_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int prio_of(logic [7:0] s, logic [2:0] b);
    for (int p = 0; p < 8; p++) if (s[3'(b + 3'(p))]) return p;
    return 8;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    logic [7:0] n_req, clr;
    logic [2:0] n_base;
    int tp;
    n_base = m_base;
    clr = '0;
    for (int i = 0; i < 8; i++) begin
      if (m_trig[i]) n_req[i] = req_i[i];
      else n_req[i] = (m_req[i] && !(ack_i && ack_lvl_i == 3'(i))) || (req_i[i] && !m_last[i]);
    end
    if (cmd_vld_i) begin
      case (cmd_code_i)
        3'd0, 3'd4: ;
        3'd1, 3'd5: begin
          tp = prio_of(m_isr, m_base);
          if (tp < 8) begin
            clr[3'(m_base + 3'(tp))] = 1'b1;
            if (cmd_code_i == 3'd5) n_base = 3'(m_base + 3'(tp) + 3'd1);
          end
        end
        3'd3: clr[cmd_lvl_i] = 1'b1;
        3'd7: begin clr[cmd_lvl_i] = 1'b1; n_base = cmd_lvl_i + 3'd1; end
        3'd6: n_base = cmd_lvl_i + 3'd1;
        default: ;
      endcase
    end
    m_isr = m_isr & ~clr;
    if (ack_i) begin
      if (auto_eoi_i) begin
        m_isr[ack_lvl_i] = 1'b0;
        if (m_rot) n_base = ack_lvl_i + 3'd1;
      end else m_isr[ack_lvl_i] = 1'b1;
    end
    if (cmd_vld_i && (cmd_code_i == 3'd0 || cmd_code_i == 3'd4)) m_rot = cmd_code_i[2];
    m_base = n_base;
    m_req  = n_req;
    m_last = req_i;
    if (mask_wr_i) m_mask = mask_i;
    if (trig_wr_i) m_trig = trig_i;
  endtask

  task automatic compare();
    logic [7:0] cur;
    int pp, cp;
    bit e_irq;
    cur = m_isr;
    if (nested_i) cur[2] = 1'b0;
    pp = prio_of(m_req & ~m_mask, m_base);
    cp = prio_of(cur, m_base);
    e_irq = pp < cp;
    check(req_o == m_req, "R1/R2 pending", int'(req_o), int'(m_req));
    check(insvc_o == m_isr, "R6 in-service", int'(insvc_o), int'(m_isr));
    check(base_o == m_base, "R10 base", int'(base_o), int'(m_base));
    check(irq_o == e_irq, "R4 irq", int'(irq_o), int'(e_irq));
    if (e_irq) check(irq_lvl_o == 3'(m_base + 3'(pp)), "R3 level", int'(irq_lvl_o),
                     int'(3'(m_base + 3'(pp))));
  endtask

  // Inputs set before the call are sampled at the next edge; outputs read 1 unit later
  task automatic step();
    @(posedge clk);
    model_update();
    #1;
    compare();
    mask_wr_i = 1'b0; trig_wr_i = 1'b0; cmd_vld_i = 1'b0; ack_i = 1'b0;
  endtask

  task automatic cmd(logic [2:0] code, logic [2:0] lvl);
    cmd_vld_i = 1'b1; cmd_code_i = code; cmd_lvl_i = lvl; step();
  endtask

  task automatic ack(logic [2:0] lvl);
    ack_i = 1'b1; ack_lvl_i = lvl; step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_req = '0; m_last = '0; m_mask = '0; m_trig = '0; m_isr = '0; m_base = '0; m_rot = 1'b0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check(req_o == 0 && insvc_o == 0 && base_o == 0 && !irq_o, "R11 reset", int'(req_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 edge capture
    req_i = 8'h08; step();
    check(req_o[3] && irq_o && irq_lvl_o == 3, "R1 rise sets", int'(irq_lvl_o), 3);
    req_i = 8'h00; step();
    check(req_o[3], "R1 fall keeps", int'(req_o), 8'h08);
    // R6 acknowledge
    ack(3);
    check(insvc_o == 8'h08 && !req_o[3] && !irq_o, "R6 ack", int'(insvc_o), 8'h08);
    // R4 lower priority held off, higher passes
    req_i = 8'h10; step();
    check(!irq_o, "R4 below in-service", int'(irq_o), 0);
    req_i = 8'h11; step();
    check(irq_o && irq_lvl_o == 0, "R4 above in-service", int'(irq_lvl_o), 0);
    // R8 non-specific EOI
    cmd(3'd1, 3'd0);
    check(insvc_o == 0, "R8 eoi top", int'(insvc_o), 0);
    // R10 / R3 rotation base
    cmd(3'd6, 3'd0);
    check(base_o == 1 && irq_lvl_o == 4, "R3 rotated pick", int'(irq_lvl_o), 4);
    cmd(3'd2, 3'd5);
    check(base_o == 1 && insvc_o == 0, "R10 idle op", int'(base_o), 1);
    ack(4);
    check(insvc_o == 8'h10 && !irq_o, "R4 rank after rotate", int'(irq_o), 0);
    cmd(3'd5, 3'd0);
    check(insvc_o == 0 && base_o == 5, "R8 eoi top rotate", int'(base_o), 5);
    // R9 specific EOI
    ack(0);
    cmd(3'd7, 3'd0);
    check(insvc_o == 0 && base_o == 1, "R9 eoi lvl rotate", int'(base_o), 1);
    ack(6);
    cmd(3'd3, 3'd6);
    check(insvc_o == 0, "R9 eoi lvl", int'(insvc_o), 0);
    // R4 mask
    req_i = 8'h40; mask_wr_i = 1'b1; mask_i = 8'h40; step();
    check(req_o[6] && !irq_o, "R4 masked", int'(irq_o), 0);
    mask_wr_i = 1'b1; mask_i = 8'h00; step();
    check(irq_o && irq_lvl_o == 6, "R4 unmasked", int'(irq_lvl_o), 6);
    // R5 nested exclusion of cascade line
    req_i = 8'h44; step();
    ack(2);
    check(!irq_o, "R4 served cascade", int'(irq_o), 0);
    req_i = 8'h40; step();
    req_i = 8'h44; step();
    check(!irq_o, "R5 nested off", int'(irq_o), 0);
    nested_i = 1'b1; step();
    check(irq_o && irq_lvl_o == 2, "R5 nested on", int'(irq_lvl_o), 2);
    nested_i = 1'b0;
    cmd(3'd3, 3'd2);
    // R2 level mode
    trig_wr_i = 1'b1; trig_i = 8'h20; step();
    req_i = 8'h64; step();
    check(req_o[5], "R2 level high", int'(req_o), 8'h20);
    ack(5);
    check(req_o[5] && insvc_o[5], "R2 ack keeps level", int'(req_o), 8'h20);
    req_i = 8'h44; step();
    check(!req_o[5], "R2 level low", int'(req_o[5]), 0);
    cmd(3'd3, 3'd5);
    // R7 auto-EOI with rotation
    cmd(3'd4, 3'd0);
    auto_eoi_i = 1'b1;
    ack(6);
    check(!insvc_o[6] && base_o == 7 && !req_o[6], "R7 auto eoi", int'(base_o), 7);
    cmd(3'd0, 3'd0);
    ack(2);
    check(base_o == 7 && !insvc_o[2], "R7 rotate off", int'(base_o), 7);
    auto_eoi_i = 1'b0;

    // Random phase
    for (int n = 0; n < 5000; n++) begin
      for (int b = 0; b < 8; b++) if ($urandom_range(0, 5) == 0) req_i[b] = ~req_i[b];
      if ($urandom_range(0, 9) == 0) begin mask_wr_i = 1'b1; mask_i = 8'($urandom); end
      if ($urandom_range(0, 19) == 0) begin trig_wr_i = 1'b1; trig_i = 8'($urandom); end
      if ($urandom_range(0, 49) == 0) nested_i = ~nested_i;
      if ($urandom_range(0, 49) == 0) auto_eoi_i = ~auto_eoi_i;
      if ($urandom_range(0, 5) == 0) begin
        cmd_vld_i = 1'b1; cmd_code_i = 3'($urandom); cmd_lvl_i = 3'($urandom);
      end
      if ($urandom_range(0, 4) == 0) begin
        ack_i = 1'b1;
        ack_lvl_i = irq_o ? irq_lvl_o : 3'($urandom);
      end
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule